// File: doc/BRIEF.md
# Rep-rate divider and trigger selector

This block derives an internal repetition-rate tick from the single reference clock. It runs the clock through three programmable dividers in a chain: a narrow first stage and two wide stages. Every stage counts only on the cycles when the stage in front of it emits its terminal pulse. Because every rate comes from that one reference, each programmed rate is exactly as accurate as the reference.

A source-select bit picks the trigger source. It is either the divided internal rate or an external trigger input, which is synchronised and edge-detected inside the block. Each accepted event of the chosen source raises a one-cycle start strobe for the downstream delay stage. At the same time it starts a trigger-out pulse whose length is programmable in reference cycles. When the select bit changes, any event in that cycle is dropped, so the switch-over never produces a stray trigger.

Top module: `reprate_trig_sel`

## Requirements
- R1: While rst_n is low on a clock edge, start_o and trig_o are 0 after that edge, and every divider restarts from count 0.
- R2: The first divider (4-bit ratio ratio0_i = N, N >= 2) emits one terminal pulse every N reference cycles. It counts 0..N-1 and pulses on count N-1.
- R3: The second and third dividers (16-bit ratios) advance only on the terminal pulse of the stage before them. With all three ratios at 2 or more, internal events recur every ratio0*ratio1*ratio2 cycles.
- R4: A ratio value of 0 or 1 makes that stage divide by one, passing every enable straight through.
- R5: A ratio written while a stage is counting is taken up only at that stage's next terminal pulse. The period in progress finishes at the old ratio.
- R6: ext_trig_i passes through two synchroniser flops and a rising-edge detector. A 0-to-1 transition first sampled at edge k raises start_o after edge k+2, for exactly one cycle per rising transition.
- R7: src_ext_i = 0 selects the internal divided rate. src_ext_i = 1 selects the external trigger. Events of the unselected source have no effect on start_o or trig_o.
- R8: Each accepted event raises start_o for one cycle, registered on the edge after the event, and trig_o rises on that same edge.
- R9: trig_o stays high for trig_len_i cycles after an event. A value of 0 selects the default of 4 cycles. A new event while the pulse is high restarts the full length.
- R10: On an edge where src_ext_i differs from its value at the previous edge, the event of that cycle is dropped: neither start_o nor a new trig_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_trig_i | input | 1 | External trigger, asynchronous to clk |
| ratio0_i | input | 4 | Ratio of the first divider stage |
| ratio1_i | input | 16 | Ratio of the second divider stage |
| ratio2_i | input | 16 | Ratio of the third divider stage |
| src_ext_i | input | 1 | Source select: 0 internal rate, 1 external trigger |
| trig_len_i | input | 4 | Trigger-out pulse length in cycles, 0 means default |
| trig_o | output | 1 | Trigger-out pulse |
| start_o | output | 1 | One-cycle start strobe for the delay stage |

## Verification
The bench builds the block with its default parameters: stage widths of 4, 16 and 16 bits, a 4-bit pulse length with a default of 4, and a two-flop synchroniser. It keeps the 16-bit ratios small, so that full cascade periods fit many times into a short run. It also mixes in the values 0 and 1 to reach the divide-by-one path in every stage. Rewriting ratios at random moments checks the deferred uptake at terminal count. Random toggling of the source select and of the external input hits the switch-over cycle, overlapping trigger pulses and the default-length code.

// File: rtl/reprate_pkg.sv
// Shared types for the rep-rate divider and trigger selector.
package reprate_pkg;
    // Trigger source selection encoding
    typedef enum logic {
        SRC_DIVIDED  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } trig_src_e;
endpackage

// File: rtl/rr_div_stage.sv
// Programmable divider stage.
// Counts enabled cycles 0..N-1 and raises tick_o on the enabled cycle at
// count N-1. A ratio of 0 or 1 divides by one. The ratio input is captured
// only on a terminal pulse, so a period in progress is never shortened.
// Assumes en_i is a one-cycle clock enable in the clk domain.
module rr_div_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] act;
    logic         last;

    // Terminal condition of the active ratio
    always_comb begin
        last   = (act <= ONE) || (cnt == act - ONE);
        tick_o = en_i && last;
    end

    // Count enabled cycles, take up the new ratio at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= '0;
        end else if (tick_o) begin
            cnt <= '0;
            act <= ratio_i;
        end else if (en_i) begin
            cnt <= cnt + ONE;
        end
    end

    // R2: the count never reaches the active ratio
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act > ONE) |-> (cnt < act));

    // R5: the active ratio only changes right after a terminal pulse
    p_ratio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_o) |-> $stable(act));
endmodule

// File: rtl/rr_ext_sync.sv
// External trigger synchroniser and rising-edge detector.
// SYNC_N flops bring the asynchronous input into the clk domain; one more
// flop holds the previous synchronised value for edge detection.
module rr_ext_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_N:0] sh;

    // Shift the input through the synchroniser and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_N-1:0], async_i};
    end

    // Rising edge of the synchronised level
    always_comb rise_o = sh[SYNC_N-1] && !sh[SYNC_N];

    // R6: one pulse per rising transition
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rr_pulse_gen.sv
// Retriggerable pulse generator for the trigger-out signal.
// A fire_i loads the length (0 selects DEF_LEN) and the output stays high
// while the down-counter is non-zero.
module rr_pulse_gen #(
    parameter int LEN_W   = 4,
    parameter int DEF_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             pulse_o
);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] DEF_V = LEN_W'(DEF_LEN);

    logic [LEN_W-1:0] cnt;

    // Load on fire, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (fire_i)     cnt <= (len_i == '0) ? DEF_V : len_i;
        else if (cnt != '0)  cnt <= cnt - ONE;
    end

    // Output is high while the count is running
    always_comb pulse_o = (cnt != '0);

    // R9: a fire always yields a high output on the next cycle
    p_fire_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o);
endmodule

// File: rtl/reprate_trig_sel.sv
// Rep-rate divider and trigger selector, top level.
// Cascades three divider stages from the reference clock, selects between
// the divided rate and the synchronised external trigger, and turns each
// accepted event into a start strobe and a trigger-out pulse. An event in
// the cycle where the select changes is dropped.
module reprate_trig_sel
    import reprate_pkg::*;
#(
    parameter int R0_W    = 4,
    parameter int R1_W    = 16,
    parameter int R2_W    = 16,
    parameter int LEN_W   = 4,
    parameter int DEF_LEN = 4,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_trig_i,
    input  logic [R0_W-1:0]  ratio0_i,
    input  logic [R1_W-1:0]  ratio1_i,
    input  logic [R2_W-1:0]  ratio2_i,
    input  logic             src_ext_i,
    input  logic [LEN_W-1:0] trig_len_i,
    output logic             trig_o,
    output logic             start_o
);
    logic      tick0, tick1, tick2;
    logic      ext_rise;
    trig_src_e sel_now, sel_q;
    logic      evt_sel;
    logic      evt_ok;

    rr_div_stage #(.W(R0_W)) u_div0 (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1), .ratio_i(ratio0_i), .tick_o(tick0));
    rr_div_stage #(.W(R1_W)) u_div1 (
        .clk(clk), .rst_n(rst_n), .en_i(tick0), .ratio_i(ratio1_i), .tick_o(tick1));
    rr_div_stage #(.W(R2_W)) u_div2 (
        .clk(clk), .rst_n(rst_n), .en_i(tick1), .ratio_i(ratio2_i), .tick_o(tick2));

    rr_ext_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_trig_i), .rise_o(ext_rise));

    // Source multiplexer with switch-over blanking
    always_comb begin
        sel_now = trig_src_e'(src_ext_i);
        evt_sel = (sel_now == SRC_EXTERNAL) ? ext_rise : tick2;
        evt_ok  = evt_sel && (sel_now == sel_q);
    end

    // Remember the select and register the start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= SRC_DIVIDED;
            start_o <= 1'b0;
        end else begin
            sel_q   <= sel_now;
            start_o <= evt_ok;
        end
    end

    rr_pulse_gen #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire_i(evt_ok), .len_i(trig_len_i), .pulse_o(trig_o));

    // R10: no start strobe after a select change
    p_sel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i != $past(src_ext_i)) |=> !start_o);

    // R8: a start strobe is always accompanied by the trigger pulse
    p_start_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> trig_o);
endmodule

// File: tb/reprate_trig_sel_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle model built from the requirements runs in
// lockstep with the design; outputs are compared on every falling edge.
module reprate_trig_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_trig_i = 1'b0;
    logic [3:0]  ratio0_i = 4'd2;
    logic [15:0] ratio1_i = 16'd2;
    logic [15:0] ratio2_i = 16'd2;
    logic        src_ext_i = 1'b0;
    logic [3:0]  trig_len_i = 4'd0;
    logic        trig_o, start_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    reprate_trig_sel dut_i (
        .clk(clk), .rst_n(rst_n), .ext_trig_i(ext_trig_i),
        .ratio0_i(ratio0_i), .ratio1_i(ratio1_i), .ratio2_i(ratio2_i),
        .src_ext_i(src_ext_i), .trig_len_i(trig_len_i),
        .trig_o(trig_o), .start_o(start_o));

    // Reference model state
    int   m_c0, m_a0, m_c1, m_a1, m_c2, m_a2, m_len;
    logic [2:0] m_sh;
    logic m_selq, m_start;

    // Terminal test of one stage for a given active ratio and count (R2, R4)
    function automatic bit stage_last(int act, int cnt);
        return (act <= 1) || (cnt == act - 1);
    endfunction

    // Pulse length with the default code applied (R9)
    function automatic int eff_len(logic [3:0] l);
        return (l == 4'd0) ? 4 : int'(l);
    endfunction

    // Cycle model advanced on each rising edge
    always @(posedge clk) begin
        bit t0, t1, t2, rise, evt;
        if (!rst_n) begin
            m_c0 <= 0; m_a0 <= 0; m_c1 <= 0; m_a1 <= 0; m_c2 <= 0; m_a2 <= 0;
            m_sh <= '0; m_selq <= 1'b0; m_start <= 1'b0; m_len <= 0;
        end else begin
            t0 = stage_last(m_a0, m_c0);
            t1 = t0 && stage_last(m_a1, m_c1);
            t2 = t1 && stage_last(m_a2, m_c2);
            if (t0) begin m_c0 <= 0; m_a0 <= int'(ratio0_i); end
            else m_c0 <= m_c0 + 1;
            if (t1) begin m_c1 <= 0; m_a1 <= int'(ratio1_i); end
            else if (t0) m_c1 <= m_c1 + 1;
            if (t2) begin m_c2 <= 0; m_a2 <= int'(ratio2_i); end
            else if (t1) m_c2 <= m_c2 + 1;
            rise = m_sh[1] && !m_sh[2];
            m_sh <= {m_sh[1:0], ext_trig_i};
            evt = (src_ext_i ? rise : t2) && (src_ext_i == m_selq);
            m_selq  <= src_ext_i;
            m_start <= evt;
            if (evt) m_len <= eff_len(trig_len_i);
            else if (m_len != 0) m_len <= m_len - 1;
        end
    end

    // Compare outputs away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_chk++;
            if (start_o !== m_start) begin
                n_bad++;
                $display("FAIL %s start_o: actual %b expected %b at %0t", cur_req, start_o, m_start, $time);
            end
            n_chk++;
            if (trig_o !== (m_len != 0)) begin
                n_bad++;
                $display("FAIL %s trig_o: actual %b expected %b at %0t", cur_req, trig_o, (m_len != 0), $time);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Random small ratio for a stage, including the divide-by-one codes
    function automatic logic [15:0] rnd_ratio();
        return 16'($urandom_range(0, 5));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs held low through reset
        @(negedge clk);
        chk_en = 1'b1;
        cycles(4);
        rst_n = 1'b1;

        // R2: first stage alone
        cur_req = "R2"; ratio0_i = 4'd5; ratio1_i = 16'd1; ratio2_i = 16'd1;
        cycles(200);
        ratio0_i = 4'd15; cycles(200);

        // R4: all stages divide by one (0 and 1 codes)
        cur_req = "R4"; ratio0_i = 4'd0; ratio1_i = 16'd1; ratio2_i = 16'd0;
        cycles(80);

        // R3: full cascade, period 3*4*2
        cur_req = "R3"; ratio0_i = 4'd3; ratio1_i = 16'd4; ratio2_i = 16'd2;
        trig_len_i = 4'd2;
        cycles(400);

        // R5: ratios rewritten at random moments
        cur_req = "R5";
        for (int i = 0; i < 150; i++) begin
            ratio0_i = 4'(rnd_ratio());
            ratio1_i = rnd_ratio();
            ratio2_i = rnd_ratio();
            cycles($urandom_range(1, 30));
        end

        // R6/R7: external source, divided rate still running
        cur_req = "R6"; src_ext_i = 1'b1; ratio0_i = 4'd2; ratio1_i = 16'd1; ratio2_i = 16'd1;
        cycles(2);
        for (int i = 0; i < 300; i++) begin
            ext_trig_i = 1'($urandom_range(0, 1));
            cycles($urandom_range(1, 6));
        end
        cur_req = "R7"; ext_trig_i = 1'b0; src_ext_i = 1'b0; cycles(2);
        for (int i = 0; i < 200; i++) begin
            ext_trig_i = ~ext_trig_i;
            cycles($urandom_range(1, 4));
        end

        // R9: pulse lengths, default code and retrigger overlap
        cur_req = "R9"; src_ext_i = 1'b1; cycles(2);
        for (int i = 0; i < 200; i++) begin
            trig_len_i = 4'($urandom_range(0, 15));
            ext_trig_i = 1'b1; cycles($urandom_range(1, 3));
            ext_trig_i = 1'b0; cycles($urandom_range(1, 20));
        end

        // R8/R10: random source switching mixed with both event streams
        cur_req = "R10"; ratio0_i = 4'd1; ratio1_i = 16'd2; ratio2_i = 16'd0;
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 3) == 0) src_ext_i = ~src_ext_i;
            ext_trig_i = 1'($urandom_range(0, 1));
            trig_len_i = 4'($urandom_range(0, 6));
            cycles($urandom_range(1, 3));
        end

        // R1: reset in mid-pulse returns everything to idle
        cur_req = "R1"; src_ext_i = 1'b0; ratio0_i = 4'd1; ratio1_i = 16'd1; trig_len_i = 4'd9;
        cycles(5);
        rst_n = 1'b0; cycles(3);
        rst_n = 1'b1; cur_req = "R8"; cycles(50);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule